// File: doc/BRIEF.md
# Parallel-to-Multilane Serializer Framer

This block takes a wide parallel word on every clock and turns it into one 7-bit word per serial lane for that clock period, plus a 7-bit word for a clock lane. A downstream shifter at seven times the clock rate sends these words out bit by bit. There are eight data lanes, and each lane carries a 6-bit slice of the 48-bit input. In balanced mode each lane also carries a flag bit. The flag tells the receiver that the slice was inverted to keep that lane's running DC content near zero. In unbalanced mode the slice goes out unchanged and the flag position is driven 0.

A training request, active low, makes the block send fixed calibration patterns on every lane in place of data. This lets a far-end receiver align its sampling strobes. While training is in progress the input is not captured and the disparity state does not move. Training can start only in balanced mode, and it lasts at least a minimum number of cycles. An active-low power-down input parks the block: the outputs are disabled and zeroed, and all encoder state is cleared.

The control is a four-state machine:
- `ST_OFF`: powered down, or in reset.
- `ST_RUN`: normal data framing.
- `ST_TRAIN_MIN`: the guaranteed minimum training period.
- `ST_TRAIN`: training held for as long as the request stays low.

The transitions are:
- Any state goes to `ST_OFF` while power-down is low.
- `ST_OFF` goes to `ST_RUN` once power-down is high.
- `ST_RUN` goes to `ST_TRAIN_MIN` when the request is low and balanced mode is selected.
- After its fixed count, `ST_TRAIN_MIN` goes to `ST_RUN` if the request is high, or to `ST_TRAIN` if it is still low.
- `ST_TRAIN` goes to `ST_RUN` when the request returns high.

Top module: `lane_framer`

## Requirements
- R1: After reset, and from the second clock edge after power-down is sampled low, `out_en_o` is 0 and `lanes_o` and `clk_word_o` are all zero.
- R2: A word presented on `din` before clock edge k appears on the lane outputs just after edge k+1 (two-cycle latency).
- R3: Lane k occupies `lanes_o[7k+6:7k]`. It carries `din[6k+5:6k]` in bits 5..0, inverted when its flag is set. Bit 6 is the flag, 1 meaning inverted.
- R4: In balanced mode, let d be the slice's count of ones minus its count of zeros, and let RD be the lane's running disparity. The slice is inverted when RD is 0, when RD>0 and d>0, or when RD<0 and d<=0. Otherwise it is sent as is.
- R5: Each lane's RD starts at 0. It adds d-1 when the slice is sent as is, and 1-d when inverted, saturating to the range -6..+7.
- R6: In unbalanced mode every lane is `{1'b0, slice}`, and RD is held.
- R7: In normal framing the clock-lane word is 7'b1111000.
- R8: During training the clock-lane word is 7'b1111100, every data lane is 7'b1111000, `din` is not captured, and RD is held.
- R9: Once training starts it lasts at least 4 cycles, even if the request returns high earlier.
- R10: A training request while `bal_en` is 0 is ignored and data framing continues.
- R11: Leaving power-down restarts every RD at 0, exactly as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 48 | Parallel input word |
| bal_en | input | 1 | 1 selects balanced mode |
| train_n | input | 1 | Training request, active low |
| pwr_n | input | 1 | Power-down, active low |
| lanes_o | output | 56 | Eight 7-bit data-lane words |
| clk_word_o | output | 7 | Clock-lane word |
| out_en_o | output | 1 | Output drivers enabled |

## Verification
The bench feeds every 6-bit value to every lane in both modes, so each lane meets every disparity against a range of running values.
- If the inversion rule is wrong at RD = 0, or for d = 0, flags appear on the wrong words.
- If the RD update is wrong, the flags drift away from the arithmetic model.

The training cases are two:
- A request of a single cycle must still produce four pattern cycles; a design that ignores the minimum resumes data too early.
- A request made in unbalanced mode must be ignored; a design that honours it sends patterns in place of data.

A power-down in the middle of a stream must zero the outputs and restart disparity; a design that keeps stale RD shows wrong flags after wake-up.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int LANE_W = 7;
    localparam int SLICE_W = LANE_W - 1;
    localparam int RD_W = 6;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_RUN       = 2'd1,
        ST_TRAIN_MIN = 2'd2,
        ST_TRAIN     = 2'd3
    } lf_state_t;

    localparam logic [LANE_W-1:0] CLK_NORMAL = 7'b1111000;
    localparam logic [LANE_W-1:0] CLK_TRAIN  = 7'b1111100;
    localparam logic [LANE_W-1:0] LANE_TRAIN = 7'b1111000;

    localparam logic signed [RD_W-1:0] RD_MAX = 6'sd7;
    localparam logic signed [RD_W-1:0] RD_MIN = -6'sd6;
endpackage

// File: rtl/lf_mode_fsm.sv
module lf_mode_fsm
    import lf_pkg::*;
#(
    parameter int MIN_TRAIN = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_n,
    input  logic      train_n,
    input  logic      bal_en,
    output lf_state_t state_q,
    output logic      load_o,
    output logic      clear_o,
    output logic      in_train_o
);
    localparam int CNT_W = $clog2(MIN_TRAIN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_TRAIN - 1);

    lf_state_t        state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!pwr_n) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:       state_d = ST_RUN;
                ST_RUN:       state_d = (!train_n && bal_en) ? ST_TRAIN_MIN : ST_RUN;
                ST_TRAIN_MIN: state_d = (cnt_q != CNT_LAST) ? ST_TRAIN_MIN
                                      : (train_n ? ST_RUN : ST_TRAIN);
                ST_TRAIN:     state_d = train_n ? ST_RUN : ST_TRAIN;
            endcase
        end
    end

    // state register and minimum-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_TRAIN_MIN)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_o     = (state_d == ST_RUN);
        clear_o    = (state_d == ST_OFF);
        in_train_o = (state_q == ST_TRAIN_MIN) || (state_q == ST_TRAIN);
    end

    assert_train_needs_balance_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_train_o) |-> $past(bal_en));

    assert_power_down_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> (state_q == ST_OFF));
endmodule

// File: rtl/lf_capture.sv
module lf_capture #(
    parameter int IN_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            clear,
    input  logic [IN_W-1:0] din,
    input  logic            bal_in,
    output logic [IN_W-1:0] cap_q,
    output logic            bal_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            bal_q <= 1'b0;
        end else if (clear) begin
            cap_q <= '0;
            bal_q <= 1'b0;
        end else if (load) begin
            cap_q <= din;
            bal_q <= bal_in;
        end
    end

    assert_hold_in_training_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clear) |=> $stable(cap_q));
endmodule

// File: rtl/lf_dc_balancer.sv
module lf_dc_balancer
    import lf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               advance,
    input  logic               bal,
    input  logic [SLICE_W-1:0] slice,
    output logic [LANE_W-1:0]  word_o
);
    logic signed [RD_W-1:0] rd_q;
    logic signed [RD_W-1:0] disp;
    logic signed [RD_W-1:0] step;
    logic signed [RD_W-1:0] sum;
    logic signed [RD_W-1:0] rd_next;
    logic                   inv;
    int                     ones;

    always_comb begin
        ones = $countones(slice);
        disp = RD_W'(2 * ones - SLICE_W);
        if (rd_q == '0)
            inv = 1'b1;
        else if (rd_q > 0)
            inv = (disp > 0);
        else
            inv = (disp <= 0);
        step = inv ? RD_W'(1 - disp) : RD_W'(disp - 1);
        sum  = rd_q + step;
        if (sum > RD_MAX)
            rd_next = RD_MAX;
        else if (sum < RD_MIN)
            rd_next = RD_MIN;
        else
            rd_next = sum;
        if (bal && inv)
            word_o = {1'b1, ~slice};
        else
            word_o = {1'b0, slice};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (clear)
            rd_q <= '0;
        else if (advance && bal)
            rd_q <= rd_next;
    end

    assert_rd_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q <= RD_MAX) && (rd_q >= RD_MIN));

    assert_clear_restarts_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd_q == '0));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(advance && bal)) |=> $stable(rd_q));
endmodule

// File: rtl/lane_framer.sv
module lane_framer
    import lf_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int MIN_TRAIN = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*SLICE_W-1:0] din,
    input  logic                    bal_en,
    input  logic                    train_n,
    input  logic                    pwr_n,
    output logic [LANES*LANE_W-1:0] lanes_o,
    output logic [LANE_W-1:0]       clk_word_o,
    output logic                    out_en_o
);
    localparam int IN_W  = LANES * SLICE_W;
    localparam int OUT_W = LANES * LANE_W;

    lf_state_t        state_q;
    logic             load;
    logic             clear;
    logic             in_train;
    logic             off_now;
    logic [IN_W-1:0]  cap_q;
    logic             cap_bal;
    logic [OUT_W-1:0] enc_words;

    lf_mode_fsm #(.MIN_TRAIN(MIN_TRAIN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_n      (pwr_n),
        .train_n    (train_n),
        .bal_en     (bal_en),
        .state_q    (state_q),
        .load_o     (load),
        .clear_o    (clear),
        .in_train_o (in_train)
    );

    lf_capture #(.IN_W(IN_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .clear  (clear),
        .din    (din),
        .bal_in (bal_en),
        .cap_q  (cap_q),
        .bal_q  (cap_bal)
    );

    assign off_now = (state_q == ST_OFF);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lf_dc_balancer u_bal (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (off_now),
            .advance (state_q == ST_RUN),
            .bal     (cap_bal),
            .slice   (cap_q[k*SLICE_W +: SLICE_W]),
            .word_o  (enc_words[k*LANE_W +: LANE_W])
        );
    end

    // output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_o    <= '0;
            clk_word_o <= '0;
            out_en_o   <= 1'b0;
        end else if (off_now) begin
            lanes_o    <= '0;
            clk_word_o <= '0;
            out_en_o   <= 1'b0;
        end else if (in_train) begin
            lanes_o    <= {LANES{LANE_TRAIN}};
            clk_word_o <= CLK_TRAIN;
            out_en_o   <= 1'b1;
        end else begin
            lanes_o    <= enc_words;
            clk_word_o <= CLK_NORMAL;
            out_en_o   <= 1'b1;
        end
    end

    assert_power_down_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> ##1 (!out_en_o && clk_word_o == '0 && lanes_o == '0));

    assert_clock_word_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o |-> (clk_word_o == CLK_NORMAL || clk_word_o == CLK_TRAIN));
endmodule

// File: tb/lane_framer_bench.sv
`timescale 1ns/1ps
module lane_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] din = '0;
    logic        bal_en = 1'b0;
    logic        train_n = 1'b1;
    logic        pwr_n = 1'b1;
    logic [55:0] lanes_o;
    logic [6:0]  clk_word_o;
    logic        out_en_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state: 0 off, 1 run, 2 train-min, 3 train
    int          ms = 0;
    int          mcnt = 0;
    logic [47:0] mcap = '0;
    logic        mbal = 1'b0;
    int          mrd[8];
    logic [55:0] e_lanes = '0;
    logic [6:0]  e_clk = '0;
    logic        e_en = 1'b0;

    always #4 clk = ~clk;

    lane_framer u_lane_framer (
        .clk(clk), .rst_n(rst_n), .din(din), .bal_en(bal_en),
        .train_n(train_n), .pwr_n(pwr_n),
        .lanes_o(lanes_o), .clk_word_o(clk_word_o), .out_en_o(out_en_o)
    );

    task automatic model_step();
        int ns;
        if (!rst_n) begin
            ms = 0; mcnt = 0; mcap = '0; mbal = 0;
            for (int k = 0; k < 8; k++) mrd[k] = 0;
            e_lanes = '0; e_clk = '0; e_en = 0;
            return;
        end
        if (ms == 0) begin
            e_en = 0; e_clk = '0; e_lanes = '0;
            for (int k = 0; k < 8; k++) mrd[k] = 0;
        end else if (ms >= 2) begin
            e_en = 1; e_clk = 7'b1111100;
            for (int k = 0; k < 8; k++) e_lanes[k*7 +: 7] = 7'b1111000;
        end else begin
            e_en = 1; e_clk = 7'b1111000;
            for (int k = 0; k < 8; k++) begin
                logic [5:0] s;
                int ones, d, r;
                bit inv;
                s = mcap[k*6 +: 6];
                if (!mbal) begin
                    e_lanes[k*7 +: 7] = {1'b0, s};
                end else begin
                    ones = 0;
                    for (int b = 0; b < 6; b++) ones += s[b];
                    d = ones - (6 - ones);
                    r = mrd[k];
                    inv = (r == 0) || (r > 0 && d > 0) || (r < 0 && d <= 0);
                    e_lanes[k*7 +: 7] = inv ? {1'b1, ~s} : {1'b0, s};
                    r = r + (inv ? 1 - d : d - 1);
                    if (r > 7) r = 7;
                    if (r < -6) r = -6;
                    mrd[k] = r;
                end
            end
        end
        if (!pwr_n) ns = 0;
        else if (ms == 0) ns = 1;
        else if (ms == 1) ns = (!train_n && bal_en) ? 2 : 1;
        else if (ms == 2) ns = (mcnt != 3) ? 2 : (train_n ? 1 : 3);
        else ns = train_n ? 1 : 3;
        mcnt = (ms == 2) ? mcnt + 1 : 0;
        if (ns == 0) begin mcap = '0; mbal = 0; end
        else if (ns == 1) begin mcap = din; mbal = bal_en; end
        ms = ns;
    endtask

    task automatic check(string tag);
        n_chk++;
        if (out_en_o !== e_en || clk_word_o !== e_clk || lanes_o !== e_lanes) begin
            n_fail++;
            $display("FAIL %s: actual en=%0b clk=%b lanes=%h expected en=%0b clk=%b lanes=%h",
                     tag, out_en_o, clk_word_o, lanes_o, e_en, e_clk, e_lanes);
        end
    endtask

    // called at a negative edge: drive, clock, model, then check at next negative edge
    task automatic cyc(logic [47:0] d, logic b, logic t, logic p, string tag);
        din = d; bal_en = b; train_n = t; pwr_n = p;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [47:0] sweep_word(int i, int mul, int off);
        logic [47:0] w;
        for (int k = 0; k < 8; k++) w[k*6 +: 6] = 6'((i * mul + k * off) & 63);
        return w;
    endfunction

    initial begin
        for (int k = 0; k < 8; k++) mrd[k] = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc('0, 1'b1, 1'b1, 1'b1, "R1 reset");
        rst_n = 1'b1;
        // R2 R3 R4 R5 R7: exhaustive slice sweep in balanced mode
        for (int i = 0; i < 64; i++) cyc(sweep_word(i, 5, 13), 1'b1, 1'b1, 1'b1, "R2 R3 R4 R5 R7 balanced sweep");
        for (int i = 0; i < 64; i++) cyc(sweep_word(i, 27, 7), 1'b1, 1'b1, 1'b1, "R4 R5 second sweep");
        for (int i = 0; i < 6; i++) cyc('0, 1'b1, 1'b1, 1'b1, "R4 R5 all zeros");
        for (int i = 0; i < 6; i++) cyc('1, 1'b1, 1'b1, 1'b1, "R4 R5 all ones");
        // R9: single-cycle request still trains four cycles
        cyc(48'h123456789abc, 1'b1, 1'b0, 1'b1, "R9 short request");
        for (int i = 0; i < 8; i++) cyc(sweep_word(i, 3, 5), 1'b1, 1'b1, 1'b1, "R9 minimum training");
        // R8: long request, input changing but ignored, RD held
        for (int i = 0; i < 10; i++) cyc(sweep_word(i, 11, 3), 1'b1, 1'b0, 1'b1, "R8 long training");
        for (int i = 0; i < 16; i++) cyc(sweep_word(i, 9, 21), 1'b1, 1'b1, 1'b1, "R8 resume after training");
        // R6 R10: unbalanced mode sweep with requests that must be ignored
        for (int i = 0; i < 64; i++)
            cyc(sweep_word(i, 5, 29), 1'b0, (i % 7) != 3, 1'b1, "R6 R10 unbalanced");
        for (int i = 0; i < 8; i++) cyc(sweep_word(i, 13, 1), 1'b1, 1'b1, 1'b1, "R6 mode change back");
        // R1 R11: power-down mid stream, then restart
        for (int i = 0; i < 4; i++) cyc(sweep_word(i, 7, 9), 1'b1, 1'b1, 1'b0, "R1 power down");
        for (int i = 0; i < 32; i++) cyc(sweep_word(i, 19, 5), 1'b1, 1'b1, 1'b1, "R11 restart after power down");
        cyc('1, 1'b1, 1'b0, 1'b0, "R1 power down overrides training");
        cyc('1, 1'b1, 1'b0, 1'b0, "R1 power down overrides training");
        for (int i = 0; i < 8; i++) cyc(sweep_word(i, 3, 17), 1'b1, 1'b1, 1'b1, "R11 second restart");
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule